// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used page table entries so that a virtual address can be turned into a physical address without a trip to memory. A lookup presents a full virtual address. The low page-offset bits pass straight through. The virtual page number above them is split into a set index (its low bits) and a tag (the rest). Every way of the indexed set is compared at once, and only valid lines take part. One cycle later the block reports either a hit, with the cached entry, the way it was found in and the physical address, or a miss.

On a miss the surrounding logic fetches the entry from the page table, which takes one extra memory access. It then hands the entry back through the refill port. The refill port overwrites a line that already holds the same page; otherwise it takes a free way or evicts the least recently used way of the set. A single flush input drops every cached translation at once.

The entry is opaque apart from its low bits, which carry the physical page number. The upper attribute bits are stored and returned unchanged.

Top module: `tlb_sa`

## Requirements
- R1: The set index is lookup address bits [PAGE_W+SET_BITS-1:PAGE_W] (refill VPN bits [SET_BITS-1:0]) and the tag is the remaining upper VPN bits; addresses with equal VPN but different offsets translate identically.
- R2: The cycle after a lookup request, exactly one of hit and miss is high; a hit needs a valid line in the indexed set with an equal tag. With no request, both are low the next cycle.
- R3: On a hit the block returns the stored entry, the way number and a physical address of entry[PPN_W-1:0] concatenated above the request's page offset; on a miss the way, entry and address outputs are zero.
- R4: A refill overwrites the lowest way in its set already holding its tag. Failing that, it takes the lowest-numbered invalid way. Failing that, it evicts the least recently used way.
- R5: Recency is tracked per set and is updated by every lookup hit and every refill; the way touched becomes most recent.
- R6: Flush clears every valid bit and resets recency (way 0 newest, the highest way oldest) in one cycle, and a refill in the same cycle is dropped.
- R7: A lookup issued in the same cycle as a refill or flush sees the contents from before that cycle.
- R8: After reset every lookup misses and hit and miss are low until a request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all cached translations |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Virtual address to translate |
| lk_hit_o | output | 1 | Registered hit result |
| lk_miss_o | output | 1 | Registered miss result |
| lk_way_o | output | WAY_W | Way that hit |
| lk_pte_o | output | PTE_W | Cached entry on hit |
| lk_pa_o | output | PPN_W+PAGE_W | Physical address on hit |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | VA_W-PAGE_W | Page number being refilled |
| fill_pte_i | input | PTE_W | Entry to store |

## Verification
The assertions rely on all inputs having known values whenever reset is released. They also rely on refills arriving only through the refill port, so that no set ever holds two valid lines with one tag. The stimulus keeps to this because it drives every input on each step and adds entries only through refills. A long pseudo-random run mixes lookups and refills over a pool of eight tags per set, so every set keeps overflowing and evicting. The expected hit, way and entry come from a bench model of the placement and recency rules, not from the design.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // How a refill chose its way.
   typedef enum logic [1:0] {
      PLACE_MATCH = 2'd0,
      PLACE_FREE  = 2'd1,
      PLACE_EVICT = 2'd2
   } place_e;
endpackage

// File: rtl/tlb_lru_set.sv
module tlb_lru_set #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             touch_a_i,
   input  logic [WAY_W-1:0] way_a_i,
   input  logic             touch_b_i,
   input  logic [WAY_W-1:0] way_b_i,
   output logic [WAY_W-1:0] victim_o
);
   typedef logic [WAYS-1:0][WAY_W-1:0] age_t;

   age_t age_q, age_a, age_d;
   logic [WAYS-1:0] oldest;

   function automatic age_t bump(input age_t cur, input logic [WAY_W-1:0] w);
      age_t nxt;
      nxt = cur;
      for (int j = 0; j < WAYS; j++) begin
         if (WAY_W'(j) == w) nxt[j] = '0;
         else if (cur[j] < cur[w]) nxt[j] = cur[j] + 1'b1;
      end
      return nxt;
   endfunction

   always_comb begin
      age_a = touch_a_i ? bump(age_q, way_a_i) : age_q;
      age_d = touch_b_i ? bump(age_a, way_b_i) : age_a;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         for (int j = 0; j < WAYS; j++) age_q[j] <= WAY_W'(j);
      end else begin
         age_q <= age_d;
      end
   end

   always_comb begin
      victim_o = '0;
      for (int j = 0; j < WAYS; j++) begin
         oldest[j] = (age_q[j] == WAY_W'(WAYS - 1));
         if (oldest[j]) victim_o = WAY_W'(j);
      end
   end

   // R5: ages stay a permutation, so exactly one way is oldest
   p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest));
   // R5: a way just refilled is never the next victim
   p_fill_not_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_b_i && !clear_i) |=> (victim_o != $past(way_b_i)));
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int IDX_W = 2,
   parameter int WAY_W = 2,
   parameter int TAG_W = 6,
   parameter int PTE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear_i,
   input  logic [IDX_W-1:0]            la_set_i,
   output logic [WAYS-1:0]             la_valid_o,
   output logic [WAYS-1:0][TAG_W-1:0]  la_tag_o,
   output logic [WAYS-1:0][PTE_W-1:0]  la_pte_o,
   input  logic [IDX_W-1:0]            fb_set_i,
   output logic [WAYS-1:0]             fb_valid_o,
   output logic [WAYS-1:0][TAG_W-1:0]  fb_tag_o,
   input  logic                        wr_en_i,
   input  logic [IDX_W-1:0]            wr_set_i,
   input  logic [WAY_W-1:0]            wr_way_i,
   input  logic [TAG_W-1:0]            wr_tag_i,
   input  logic [PTE_W-1:0]            wr_pte_i
);
   logic [SETS-1:0][WAYS-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [PTE_W-1:0] pte_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) valid_q <= '0;
      else if (wr_en_i) valid_q[wr_set_i][wr_way_i] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
         pte_q[wr_set_i][wr_way_i] <= wr_pte_i;
      end
   end

   always_comb begin
      la_valid_o = valid_q[la_set_i];
      fb_valid_o = valid_q[fb_set_i];
      for (int w = 0; w < WAYS; w++) begin
         la_tag_o[w] = tag_q[la_set_i][w];
         la_pte_o[w] = pte_q[la_set_i][w];
         fb_tag_o[w] = tag_q[fb_set_i][w];
      end
   end

   // R6: a flush leaves no valid line behind
   p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (valid_q == '0));
   // R4: a written line is valid the next cycle
   p_write_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clear_i) |=> valid_q[$past(wr_set_i)][$past(wr_way_i)]);
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
   import tlb_pkg::*;
#(
   parameter int VA_W     = 16,
   parameter int PAGE_W   = 8,
   parameter int SET_BITS = 2,
   parameter int WAYS     = 4,
   parameter int PPN_W    = 6,
   parameter int PTE_W    = 8,
   localparam int VPN_W   = VA_W - PAGE_W,
   localparam int TAG_W   = VPN_W - SET_BITS,
   localparam int SETS    = 1 << SET_BITS,
   localparam int IDX_W   = (SET_BITS > 0) ? SET_BITS : 1,
   localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int PA_W    = PPN_W + PAGE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             lk_valid_i,
   input  logic [VA_W-1:0]  lk_va_i,
   output logic             lk_hit_o,
   output logic             lk_miss_o,
   output logic [WAY_W-1:0] lk_way_o,
   output logic [PTE_W-1:0] lk_pte_o,
   output logic [PA_W-1:0]  lk_pa_o,
   input  logic             fill_valid_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PTE_W-1:0] fill_pte_i
);
   if (TAG_W < 1) begin : g_bad_split
      $error("tlb_sa: address too narrow for page and index bits");
   end
   if (PTE_W < PPN_W) begin : g_bad_pte
      $error("tlb_sa: entry narrower than physical page number");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("tlb_sa: WAYS must be a power of two, at least 2");
   end

   logic [IDX_W-1:0] lk_set, fl_set;
   logic [TAG_W-1:0] lk_tag, fl_tag;

   assign lk_tag = lk_va_i[VA_W-1:PAGE_W+SET_BITS];
   assign fl_tag = fill_vpn_i[VPN_W-1:SET_BITS];

   if (SET_BITS > 0) begin : g_indexed
      assign lk_set = lk_va_i[PAGE_W+SET_BITS-1:PAGE_W];
      assign fl_set = fill_vpn_i[SET_BITS-1:0];
   end else begin : g_full_assoc
      assign lk_set = '0;
      assign fl_set = '0;
   end

   logic [WAYS-1:0]            la_valid, fb_valid;
   logic [WAYS-1:0][TAG_W-1:0] la_tag, fb_tag;
   logic [WAYS-1:0][PTE_W-1:0] la_pte;
   logic                       fill_en;
   logic [WAY_W-1:0]           fl_way;
   place_e                     place;

   assign fill_en = fill_valid_i && !flush_i;

   tlb_store #(
      .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W),
      .TAG_W(TAG_W), .PTE_W(PTE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clear_i(flush_i),
      .la_set_i(lk_set), .la_valid_o(la_valid), .la_tag_o(la_tag), .la_pte_o(la_pte),
      .fb_set_i(fl_set), .fb_valid_o(fb_valid), .fb_tag_o(fb_tag),
      .wr_en_i(fill_en), .wr_set_i(fl_set), .wr_way_i(fl_way),
      .wr_tag_i(fl_tag), .wr_pte_i(fill_pte_i)
   );

   // Lookup compare: lowest matching way wins.
   logic [WAYS-1:0]  lk_match;
   logic             hit_any;
   logic [WAY_W-1:0] hit_way;
   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         lk_match[w] = la_valid[w] && (la_tag[w] == lk_tag);
         if (lk_match[w]) hit_way = WAY_W'(w);
      end
      hit_any = |lk_match;
   end

   // Recency state, one instance per set.
   logic [WAY_W-1:0] victim [SETS];
   for (genvar s = 0; s < SETS; s++) begin : g_lru
      tlb_lru_set #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
         .clk(clk), .rst_n(rst_n), .clear_i(flush_i),
         .touch_a_i(lk_valid_i && hit_any && (lk_set == IDX_W'(s))),
         .way_a_i(hit_way),
         .touch_b_i(fill_en && (fl_set == IDX_W'(s))),
         .way_b_i(fl_way),
         .victim_o(victim[s])
      );
   end

   // Refill placement: same tag, then lowest free way, then oldest way.
   logic [WAYS-1:0]  fl_match;
   logic [WAY_W-1:0] match_way, free_way;
   always_comb begin
      match_way = '0;
      free_way  = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         fl_match[w] = fb_valid[w] && (fb_tag[w] == fl_tag);
         if (fl_match[w]) match_way = WAY_W'(w);
         if (!fb_valid[w]) free_way = WAY_W'(w);
      end
      if (|fl_match) begin
         place  = PLACE_MATCH;
         fl_way = match_way;
      end else if (!(&fb_valid)) begin
         place  = PLACE_FREE;
         fl_way = free_way;
      end else begin
         place  = PLACE_EVICT;
         fl_way = victim[fl_set];
      end
   end

   // Registered lookup result.
   always_ff @(posedge clk) begin
      if (!rst_n || !lk_valid_i) begin
         lk_hit_o  <= 1'b0;
         lk_miss_o <= 1'b0;
         lk_way_o  <= '0;
         lk_pte_o  <= '0;
         lk_pa_o   <= '0;
      end else begin
         lk_hit_o  <= hit_any;
         lk_miss_o <= !hit_any;
         lk_way_o  <= hit_any ? hit_way : '0;
         lk_pte_o  <= hit_any ? la_pte[hit_way] : '0;
         lk_pa_o   <= hit_any ? {la_pte[hit_way][PPN_W-1:0], lk_va_i[PAGE_W-1:0]} : '0;
      end
   end

   // R2: each request yields exactly one of hit or miss
   p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> (lk_hit_o != lk_miss_o));
   // R2: no request, no result
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |=> (!lk_hit_o && !lk_miss_o));
   // R3: page offset passes through on a hit
   p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> (!lk_hit_o || lk_pa_o[PAGE_W-1:0] == $past(lk_va_i[PAGE_W-1:0])));
   // R4: eviction happens only when the set is full
   p_evict_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && place == PLACE_EVICT) |-> (&fb_valid));
   // R4: tags in a set never duplicate, so at most one way matches
   p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
endmodule

// File: tb/tlb_sa_test.sv
`timescale 1ns/1ps
module tlb_sa_test;
   localparam int VA_W = 16, PAGE_W = 8, SET_BITS = 2, WAYS = 4, PPN_W = 6, PTE_W = 8;
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PA_W = PPN_W + PAGE_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0, lk_valid = 1'b0, fill_valid = 1'b0;
   logic [VA_W-1:0]  lk_va = '0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PTE_W-1:0] fill_pte = '0;
   logic             hit, miss;
   logic [1:0]       way;
   logic [PTE_W-1:0] pte;
   logic [PA_W-1:0]  pa;

   always #2 clk = ~clk;

   tlb_sa uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .lk_valid_i(lk_valid), .lk_va_i(lk_va),
      .lk_hit_o(hit), .lk_miss_o(miss), .lk_way_o(way), .lk_pte_o(pte), .lk_pa_o(pa),
      .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pte_i(fill_pte)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // Reference model of the contents and recency ranks.
   bit       mv [4][4];
   bit [5:0] mt [4][4];
   bit [7:0] mp [4][4];
   int       ma [4][4];

   task automatic m_clear();
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 4; w++) begin mv[s][w] = 0; ma[s][w] = w; end
   endtask

   task automatic m_touch(input int s, input int w);
      int ref_age;
      ref_age = ma[s][w];
      for (int j = 0; j < 4; j++)
         if (j == w) ma[s][j] = 0;
         else if (ma[s][j] < ref_age) ma[s][j]++;
   endtask

   function automatic int m_find(input int s, input bit [5:0] t);
      for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) return w;
      return -1;
   endfunction

   function automatic int m_place(input int s, input bit [5:0] t);
      int w;
      w = m_find(s, t);
      if (w >= 0) return w;
      for (int j = 0; j < 4; j++) if (!mv[s][j]) return j;
      for (int j = 0; j < 4; j++) if (ma[s][j] == 3) return j;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock step; called with time at a falling edge.
   task automatic step(input bit lv, input bit [15:0] va, input bit fv,
                       input bit [7:0] fvpn, input bit [7:0] fpte, input bit fl,
                       input string req);
      int ls, lw, fs, fw;
      bit [5:0] lt, ft;
      lk_valid = lv; lk_va = va; fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte; flush = fl;
      ls = va[9:8]; lt = va[15:10];
      fs = fvpn[1:0]; ft = fvpn[7:2];
      lw = lv ? m_find(ls, lt) : -1;   // R7: sees contents before this cycle
      fw = m_place(fs, ft);
      if (lw >= 0) m_touch(ls, lw);
      if (fv && !fl) begin
         mv[fs][fw] = 1; mt[fs][fw] = ft; mp[fs][fw] = fpte; m_touch(fs, fw);
      end
      if (fl) m_clear();
      @(posedge clk);
      @(negedge clk);
      lk_valid = 0; fill_valid = 0; flush = 0;
      if (!lv) begin
         chk(!hit && !miss, {req, " R2 idle"}, {hit, miss}, 0);
      end else if (lw < 0) begin
         chk(!hit && miss, {req, " R2 miss"}, {hit, miss}, 1);
         chk(way == 0 && pte == 0 && pa == 0, {req, " R3 miss zero"}, pa, 0);
      end else begin
         chk(hit && !miss, {req, " R2 hit"}, {hit, miss}, 2);
         chk(way == 2'(lw), {req, " R4 way"}, way, lw);
         chk(pte == mp[ls][lw], {req, " R3 entry"}, pte, mp[ls][lw]);
         chk(pa == {mp[ls][lw][5:0], va[7:0]}, {req, " R3 address"}, pa, {mp[ls][lw][5:0], va[7:0]});
      end
   endtask

   task automatic look(input bit [15:0] va, input string req);
      step(1, va, 0, 0, 0, 0, req);
   endtask

   task automatic fill(input bit [7:0] vpn, input bit [7:0] p, input string req);
      step(0, 0, 1, vpn, p, 0, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit [31:0] seed;
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!hit && !miss && pa == 0, "R8 reset outputs", {hit, miss}, 0);

      // R8, R1: every page misses when empty, offsets vary
      for (int v = 0; v < 256; v++) look(16'(v << 8) | 16'((v * 37) & 8'hff), "R8 empty");

      // R4 free placement, R1 index split: four tags per set
      for (int t = 0; t < 4; t++)
         for (int s = 0; s < 4; s++) fill(8'((t * 9) << 2 | s), 8'(t * 64 + s * 16 + 5), "R4 free fill");
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < 4; t++) begin
            look({6'(t * 9), 2'(s), 8'h00}, "R1 hit");
            look({6'(t * 9), 2'(s), 8'hff}, "R1 offset");
         end

      // R4 same tag refill keeps its way, R5 recency order
      fill({6'd9, 2'd1}, 8'hA3, "R4 refresh");
      look({6'd9, 2'd1, 8'h42}, "R4 refreshed");
      fill({6'd50, 2'd1}, 8'h11, "R5 evict");
      look({6'd0, 2'd1, 8'h01}, "R5 after evict");

      // R5, R4: pseudo-random mix over eight tags per set
      seed = 32'h1234_5678;
      for (int i = 0; i < 4000; i++) begin
         bit [2:0] tg; bit [1:0] st; bit [7:0] off;
         seed = seed * 32'd1103515245 + 32'd12345;
         tg = seed[18:16]; st = seed[21:20]; off = seed[31:24];
         if (seed[23:22] == 2'b00) fill({3'(tg), tg, st}, off, "R5 mix fill");
         else look({3'(tg), tg, st, off}, "R5 mix look");
      end

      // R7: lookup concurrent with refill of the same page
      step(1, {6'd60, 2'd2, 8'h10}, 1, {6'd60, 2'd2}, 8'h77, 0, "R7 fill overlap");
      look({6'd60, 2'd2, 8'h10}, "R7 after fill");
      // R7: lookup concurrent with flush sees old contents; R6: refill dropped
      step(1, {6'd60, 2'd2, 8'h20}, 1, {6'd61, 2'd3}, 8'h55, 1, "R7 flush overlap");
      look({6'd60, 2'd2, 8'h20}, "R6 flushed");
      look({6'd61, 2'd3, 8'h20}, "R6 dropped fill");
      for (int v = 0; v < 256; v += 7) look(16'(v << 8), "R6 all empty");
      // R6: recency reset, refill order restarts at way 0
      for (int t = 0; t < 5; t++) fill({6'(t + 20), 2'd0}, 8'(t + 1), "R6 refill");
      for (int t = 0; t < 5; t++) look({6'(t + 20), 2'd0, 8'h0F}, "R6 order");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule